// File: doc/BRIEF.md
# Firmware Hub Cycle Target on a 4-bit Multiplexed Bus

This block is the peripheral end of a firmware-memory link that carries command, address and data as 4-bit nibbles on a shared bus, with a separate active-low frame strobe. Each rising clock edge, the target looks at the nibble bus and the strobe. It recognises only two start codes, one for a read and one for a write. It takes part in a cycle only when the select nibble matches its strapped identity. It then gathers a 28-bit address and a size nibble, and on a write it also takes in one data byte. After that it returns turnaround, sync and read-data nibbles through an output-enable that controls the bus driver.

Toward the storage behind it, the target issues a single-byte request that is held until a ready input is seen. While the storage has not answered, the target keeps the host waiting with wait-sync nibbles. A read always gives at least `MIN_WAIT` wait-sync clocks before the ready-sync. If the strobe is pulled low in the middle of any cycle, the cycle is dropped, the bus is released at once, and the strobe clock itself is decoded as a possible new start.

The controller is one state machine (`fwh_state_e`):
- `S_IDLE` goes to `S_IDSEL` when a start code is seen.
- `S_IDSEL` goes to `S_ADDR` when the select nibble matches, and back to `S_IDLE` otherwise.
- `S_ADDR` stays for `ADDR_NIBBLES` clocks, then goes to `S_SIZE`.
- `S_SIZE` returns to `S_IDLE` on a size other than one byte. Otherwise it goes to `S_WDLO`/`S_WDHI` for a write or straight to `S_TAR1` for a read.
- `S_TAR1` goes to `S_TAR2`, then to `S_SYNC`.
- `S_SYNC` stays until the sync condition holds. It then goes to `S_RDLO`, `S_RDHI` for a read, or straight to `S_RTAR1` for a write.
- `S_RTAR1` goes to `S_RTAR2`, then to `S_IDLE`.
- From every state, a low strobe leads to `S_IDSEL` when a start code is present, or to `S_IDLE` when it is not (the abort transition).

Top module: `fwh_lpc_target`

## Requirements
- R1: While and right after `rst_n` is low, `lad_oe` and `mem_req` are 0.
- R2: A cycle starts only on a clock where `frame_n`=0 and `lad_in` is 4'b1101 (read) or 4'b1110 (write). Any other nibble with `frame_n`=0 is ignored: the bus is not driven and no request is made. The target never drives during the host's header clocks.
- R3: The clock after the start carries the select nibble. A value different from `id_strap` ends the cycle with no driving and no request.
- R4: The next 7 clocks carry a 28-bit address, most significant nibble first, and it is presented on `mem_addr`.
- R5: One size nibble follows the address. Only 4'b0000 (one byte) continues the cycle; any other value ends it with no driving and no request.
- R6: After the size nibble (read) or after the write data (write), the target leaves `lad_oe`=0 for exactly two turnaround clocks.
- R7: On a read, the target next drives 4'b0101 for at least `MIN_WAIT` (2) clocks and until the storage has returned the byte. It then drives 4'b0000 for one clock.
- R8: On a read, the byte follows in two clocks, low nibble first. Then the target drives 4'b1111 for one clock and sets `lad_oe`=0 on the next.
- R9: On a write, two host clocks after the size nibble carry the byte, low nibble first, and it is presented on `mem_wdata` with `mem_we`=1. After the turnaround the target drives 4'b0101 until the storage accepts the write, then one 4'b0000 clock. Then it drives 4'b1111 for one clock and floats.
- R10: A clock with `frame_n`=0 in the middle of a cycle aborts it: `lad_oe` and `mem_req` are 0 on the next clock. If that clock carried a start code, it begins a new cycle.
- R11: `mem_req` stays high with a stable `mem_addr` until `mem_ready` is sampled high. Each cycle makes exactly one transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| frame_n | input | 1 | Active-low frame strobe from the host |
| lad_in | input | 4 | Nibble bus as seen by the target |
| lad_out | output | 4 | Nibble the target drives |
| lad_oe | output | 1 | Output enable for the nibble bus driver |
| id_strap | input | 4 | Strapped identity nibble |
| mem_req | output | 1 | Byte request toward the storage |
| mem_we | output | 1 | 1 for a write request, 0 for a read |
| mem_addr | output | 28 | Byte address of the request |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte from the storage |
| mem_ready | input | 1 | Storage has completed the request |

## Verification
The bench goes through all sixteen start nibbles, all sixteen strap values with a matching select nibble and a mismatching one, and every non-zero size nibble. A design that decoded too loosely would drive the bus or issue a stray request in these cases. Storage latencies from zero to several clocks check the wait-sync count against max(2, latency−1) for reads and max(0, latency−1) for writes. An off-by-one in the sync rule, or a missing minimum wait, shows up there as a wrong count of 4'b0101 clocks. Aborts inside the sync phase and inside the address phase check that a design keeping the bus or the request after the strobe is caught, and that a restart on the strobe clock is still accepted. The nibble order of the address and data checks designs that reverse either one.

// File: rtl/fwh_pkg.sv
package fwh_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_IDSEL,
        S_ADDR,
        S_SIZE,
        S_WDLO,
        S_WDHI,
        S_TAR1,
        S_TAR2,
        S_SYNC,
        S_RDLO,
        S_RDHI,
        S_RTAR1,
        S_RTAR2
    } fwh_state_e;

    localparam logic [3:0] CODE_READ  = 4'b1101;
    localparam logic [3:0] CODE_WRITE = 4'b1110;
    localparam logic [3:0] CODE_WAIT  = 4'b0101;
    localparam logic [3:0] CODE_READY = 4'b0000;
    localparam logic [3:0] CODE_TURN  = 4'b1111;
    localparam logic [3:0] CODE_BYTE  = 4'b0000;

endpackage

// File: rtl/fwh_nibble_collect.sv
module fwh_nibble_collect #(
    parameter int NIBBLES   = 7,
    parameter bit MSB_FIRST = 1'b1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   shift,
    input  logic [3:0]             nib,
    output logic [4*NIBBLES-1:0]   value
);
    localparam int W = 4 * NIBBLES;

    generate
        if (MSB_FIRST) begin : g_msb
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    value <= '0;
                else if (shift)
                    value <= {value[W-5:0], nib};
            end
        end else begin : g_lsb
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    value <= '0;
                else if (shift)
                    value <= {nib, value[W-1:4]};
            end
        end
    endgenerate

endmodule

// File: rtl/fwh_phase_count.sv
module fwh_phase_count #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    output logic [W-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count <= '0;
        else if (clear)
            count <= '0;
        else if (count != {W{1'b1}})
            count <= count + 1'b1;
    end

endmodule

// File: rtl/fwh_lpc_target.sv
module fwh_lpc_target
    import fwh_pkg::*;
#(
    parameter int ADDR_NIBBLES = 7,
    parameter int MIN_WAIT     = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      frame_n,
    input  logic [3:0]                lad_in,
    output logic [3:0]                lad_out,
    output logic                      lad_oe,
    input  logic [3:0]                id_strap,
    output logic                      mem_req,
    output logic                      mem_we,
    output logic [4*ADDR_NIBBLES-1:0] mem_addr,
    output logic [7:0]                mem_wdata,
    input  logic [7:0]                mem_rdata,
    input  logic                      mem_ready
);
    localparam int CNT_MAX = (ADDR_NIBBLES > MIN_WAIT) ? ADDR_NIBBLES : MIN_WAIT;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_NIBBLES - 1);
    localparam logic [CNT_W-1:0] WAIT_MIN  = CNT_W'(MIN_WAIT);

    fwh_state_e       state, nxt;
    logic             is_wr;
    logic             done;
    logic [7:0]       rd_byte;
    logic [CNT_W-1:0] cnt;
    logic             start_ok;
    logic             sync_go;
    logic             xfer;

    assign start_ok = !frame_n && (lad_in == CODE_READ || lad_in == CODE_WRITE);
    assign sync_go  = done && (is_wr || cnt >= WAIT_MIN);
    assign xfer     = mem_req && mem_ready;

    fwh_phase_count #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (nxt != state),
        .count (cnt)
    );

    fwh_nibble_collect #(.NIBBLES(ADDR_NIBBLES), .MSB_FIRST(1'b1)) u_addr (
        .clk   (clk),
        .rst_n (rst_n),
        .shift (frame_n && state == S_ADDR),
        .nib   (lad_in),
        .value (mem_addr)
    );

    fwh_nibble_collect #(.NIBBLES(2), .MSB_FIRST(1'b0)) u_wdata (
        .clk   (clk),
        .rst_n (rst_n),
        .shift (frame_n && (state == S_WDLO || state == S_WDHI)),
        .nib   (lad_in),
        .value (mem_wdata)
    );

    always_comb begin
        nxt = state;
        if (!frame_n) begin
            nxt = start_ok ? S_IDSEL : S_IDLE;
        end else begin
            unique case (state)
                S_IDLE:  nxt = S_IDLE;
                S_IDSEL: nxt = (lad_in == id_strap) ? S_ADDR : S_IDLE;
                S_ADDR:  if (cnt == ADDR_LAST) nxt = S_SIZE;
                S_SIZE:  nxt = (lad_in != CODE_BYTE) ? S_IDLE : (is_wr ? S_WDLO : S_TAR1);
                S_WDLO:  nxt = S_WDHI;
                S_WDHI:  nxt = S_TAR1;
                S_TAR1:  nxt = S_TAR2;
                S_TAR2:  nxt = S_SYNC;
                S_SYNC:  if (sync_go) nxt = is_wr ? S_RTAR1 : S_RDLO;
                S_RDLO:  nxt = S_RDHI;
                S_RDHI:  nxt = S_RTAR1;
                S_RTAR1: nxt = S_RTAR2;
                S_RTAR2: nxt = S_IDLE;
                default: nxt = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            is_wr   <= 1'b0;
            done    <= 1'b0;
            rd_byte <= '0;
        end else begin
            state <= nxt;
            if (start_ok) begin
                is_wr <= (lad_in == CODE_WRITE);
                done  <= 1'b0;
            end else if (xfer) begin
                done <= 1'b1;
            end
            if (xfer && !is_wr)
                rd_byte <= mem_rdata;
        end
    end

    always_comb begin
        lad_oe  = 1'b0;
        lad_out = CODE_TURN;
        mem_req = !done && (state == S_TAR1 || state == S_TAR2 || state == S_SYNC);
        mem_we  = is_wr;
        unique case (state)
            S_SYNC: begin
                lad_oe  = 1'b1;
                lad_out = sync_go ? CODE_READY : CODE_WAIT;
            end
            S_RDLO: begin
                lad_oe  = 1'b1;
                lad_out = rd_byte[3:0];
            end
            S_RDHI: begin
                lad_oe  = 1'b1;
                lad_out = rd_byte[7:4];
            end
            S_RTAR1: begin
                lad_oe  = 1'b1;
                lad_out = CODE_TURN;
            end
            default: begin
                lad_oe  = 1'b0;
                lad_out = CODE_TURN;
            end
        endcase
    end

    // R10: a strobe clock releases the bus and the request on the next clock
    p_abort_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_n |=> (!lad_oe && !mem_req));

    // R11: an unanswered request is held with a steady address and direction
    p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready && frame_n) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R6: the clock after the size nibble is never driven by the target
    p_turn_float_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_SIZE && frame_n) |=> !lad_oe);

    // R7: a ready-sync is followed by a driven clock (data or final turnaround)
    p_ready_then_drive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_SYNC && lad_out == CODE_READY && frame_n) |=> (lad_oe && !mem_req));

    // R8: after the driven turnaround the bus is floated with no request
    p_tar_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RTAR1 && frame_n) |=> (!lad_oe && !mem_req));

endmodule

// File: tb/fwh_lpc_target_tb.sv
module fwh_lpc_target_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_n = 1'b1;
    logic [3:0]  lad_in = 4'hF;
    logic [3:0]  lad_out;
    logic        lad_oe;
    logic [3:0]  id_strap = 4'h0;
    logic        mem_req;
    logic        mem_we;
    logic [27:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata;
    logic        mem_ready;

    int nchk = 0;
    int nfail = 0;
    int mem_lat = 0;
    int wcnt = 0;
    int req_seen = 0;
    int hs_count = 0;
    logic [27:0] log_addr;
    logic [7:0]  log_data;
    logic        log_we;
    logic        s_oe;
    logic [3:0]  s_out;

    always #2 clk = ~clk;

    fwh_lpc_target u_dut (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .lad_in(lad_in),
        .lad_out(lad_out), .lad_oe(lad_oe), .id_strap(id_strap),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
    );

    function automatic logic [7:0] store_byte(input logic [27:0] a);
        return a[7:0] ^ a[15:8] ^ a[27:20] ^ 8'hA5;
    endfunction

    // storage model: answers after mem_lat clocks of request
    initial begin
        mem_ready = 1'b0;
        mem_rdata = 8'h00;
        forever begin
            @(negedge clk);
            if (mem_req) begin
                req_seen++;
                if (wcnt >= mem_lat) begin
                    mem_ready = 1'b1;
                    mem_rdata = store_byte(mem_addr);
                    hs_count++;
                    log_addr = mem_addr;
                    log_data = mem_wdata;
                    log_we   = mem_we;
                end else begin
                    mem_ready = 1'b0;
                    wcnt++;
                end
            end else begin
                mem_ready = 1'b0;
                wcnt = 0;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input logic f, input logic [3:0] v);
        @(negedge clk);
        frame_n = f;
        lad_in  = v;
        s_oe    = lad_oe;
        s_out   = lad_out;
    endtask

    task automatic send_hdr(input logic [3:0] code, input logic [3:0] id,
                            input logic [27:0] a, input logic [3:0] size);
        cyc(1'b0, code);
        check(!s_oe, "R2 start clock undriven", s_oe, 0);
        cyc(1'b1, id);
        check(!s_oe, "R3 select clock undriven", s_oe, 0);
        for (int i = 6; i >= 0; i--) begin
            cyc(1'b1, a[4*i +: 4]);
            check(!s_oe, "R4 address clock undriven", s_oe, 0);
        end
        cyc(1'b1, size);
        check(!s_oe, "R5 size clock undriven", s_oe, 0);
    endtask

    task automatic wait_sync(output int waits, output bit got);
        waits = 0;
        got = 1'b0;
        for (int i = 0; i < 64; i++) begin
            cyc(1'b1, 4'hF);
            if (!s_oe) break;
            if (s_out == 4'b0101) waits++;
            else begin
                got = (s_out == 4'b0000);
                break;
            end
        end
    endtask

    task automatic do_read(input logic [3:0] id, input logic [27:0] a, input int lat);
        int waits, expw, base;
        bit got;
        logic [7:0] eb;
        mem_lat = lat;
        base = hs_count;
        eb = store_byte(a);
        expw = (lat - 1 > 2) ? lat - 1 : 2;
        send_hdr(4'b1101, id, a, 4'b0000);
        cyc(1'b1, 4'hF);
        check(!s_oe, "R6 read turnaround 1", s_oe, 0);
        cyc(1'b1, 4'hF);
        check(!s_oe, "R6 read turnaround 2", s_oe, 0);
        wait_sync(waits, got);
        check(got, "R7 ready-sync seen", got, 1);
        check(waits == expw, "R7 wait-sync count", waits, expw);
        cyc(1'b1, 4'hF);
        check(s_oe && s_out == eb[3:0], "R8 low nibble", s_out, eb[3:0]);
        cyc(1'b1, 4'hF);
        check(s_oe && s_out == eb[7:4], "R8 high nibble", s_out, eb[7:4]);
        cyc(1'b1, 4'hF);
        check(s_oe && s_out == 4'hF, "R8 driven turnaround", s_out, 4'hF);
        cyc(1'b1, 4'hF);
        check(!s_oe, "R8 release", s_oe, 0);
        check(hs_count == base + 1, "R11 one transfer per read", hs_count - base, 1);
        check(log_addr == a && !log_we, "R4 read address", log_addr, a);
    endtask

    task automatic do_write(input logic [3:0] id, input logic [27:0] a,
                            input logic [7:0] d, input int lat);
        int waits, expw, base;
        bit got;
        mem_lat = lat;
        base = hs_count;
        expw = (lat > 1) ? lat - 1 : 0;
        send_hdr(4'b1110, id, a, 4'b0000);
        cyc(1'b1, d[3:0]);
        check(!s_oe, "R9 data low undriven", s_oe, 0);
        cyc(1'b1, d[7:4]);
        check(!s_oe, "R9 data high undriven", s_oe, 0);
        cyc(1'b1, 4'hF);
        check(!s_oe, "R6 write turnaround 1", s_oe, 0);
        cyc(1'b1, 4'hF);
        check(!s_oe, "R6 write turnaround 2", s_oe, 0);
        wait_sync(waits, got);
        check(got, "R9 ready-sync seen", got, 1);
        check(waits == expw, "R9 wait-sync count", waits, expw);
        cyc(1'b1, 4'hF);
        check(s_oe && s_out == 4'hF, "R9 driven turnaround", s_out, 4'hF);
        cyc(1'b1, 4'hF);
        check(!s_oe, "R9 release", s_oe, 0);
        check(hs_count == base + 1, "R11 one transfer per write", hs_count - base, 1);
        check(log_we && log_addr == a, "R9 write address", log_addr, a);
        check(log_data == d, "R9 write byte order", log_data, d);
    endtask

    task automatic ignored(input logic [3:0] code, input logic [3:0] id,
                           input logic [3:0] size, input string req);
        int base;
        bit any;
        base = req_seen;
        any = 1'b0;
        send_hdr(code, id, 28'h5A5A5A5, size);
        for (int i = 0; i < 14; i++) begin
            cyc(1'b1, 4'h0);
            if (s_oe) any = 1'b1;
        end
        check(!any, req, any, 0);
        check(req_seen == base, req, req_seen - base, 0);
    endtask

    initial begin
        #(4 * 150000);
        nchk++;
        nfail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) begin
            cyc(1'b1, 4'hF);
            check(!s_oe && !mem_req, "R1 during reset", s_oe, 0);
        end
        @(negedge clk);
        rst_n = 1'b1;
        cyc(1'b1, 4'hF);
        check(!s_oe && !mem_req, "R1 after reset", s_oe, 0);

        // R2: start-code sweep
        for (int c = 0; c < 16; c++) begin
            if (c != 13 && c != 14)
                ignored(4'(c), 4'h0, 4'h0, "R2 other start ignored");
        end
        do_read(4'h0, 28'h0123456, 0);
        do_write(4'h0, 28'hFEDCBA9, 8'h3C, 0);

        // R3: strap sweep with match and mismatch
        for (int s = 0; s < 16; s++) begin
            id_strap = 4'(s);
            do_read(4'(s), 28'(s * 28'h1234567 + 28'h0A0B0C0), s % 6);
            ignored(4'b1101, 4'(s + 1), 4'h0, "R3 select mismatch ignored");
        end
        id_strap = 4'h9;

        // R5: size sweep
        for (int z = 1; z < 16; z++)
            ignored(4'b1101, 4'h9, 4'(z), "R5 bad size ignored");
        ignored(4'b1110, 4'h9, 4'h1, "R5 bad write size ignored");

        // R7 / R9: latency sweep
        for (int l = 0; l < 6; l++) begin
            do_read(4'h9, 28'(28'h0F00000 + l * 28'h1111), l);
            do_write(4'h9, 28'(28'h7000000 + l * 28'h0305), 8'(8'h81 + l * 8'h17), l);
        end

        // R10: abort inside the sync phase
        mem_lat = 40;
        send_hdr(4'b1101, 4'h9, 28'h1357ACE, 4'h0);
        cyc(1'b1, 4'hF);
        cyc(1'b1, 4'hF);
        cyc(1'b1, 4'hF);
        check(s_oe && s_out == 4'b0101, "R10 waiting before abort", s_out, 5);
        cyc(1'b0, 4'h0);
        cyc(1'b1, 4'hF);
        check(!s_oe && !mem_req, "R10 released after abort", s_oe, 0);
        cyc(1'b1, 4'hF);
        cyc(1'b1, 4'hF);
        do_read(4'h9, 28'h2468BDF, 1);

        // R10: restart from inside the address phase
        cyc(1'b0, 4'b1110);
        cyc(1'b1, 4'h9);
        cyc(1'b1, 4'h1);
        cyc(1'b1, 4'h2);
        do_read(4'h9, 28'hCAFE123, 3);

        // R10: abort inside the write data phase, then a write
        send_hdr(4'b1110, 4'h9, 28'h0000001, 4'h0);
        cyc(1'b1, 4'h6);
        cyc(1'b0, 4'hF);
        cyc(1'b1, 4'hF);
        check(!s_oe && !mem_req, "R10 released after write abort", s_oe, 0);
        do_write(4'h9, 28'h0ABCDEF, 8'hE7, 2);

        cyc(1'b1, 4'hF);
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule